// File: doc/BRIEF.md
# Permission-Checking Translation Cache

This block is a small, fully associative cache of page translations. Each entry holds a virtual page number as its tag, the physical frame number for that page, and the page's access rights. For every lookup the virtual page number is compared with all valid entries at once.

On a match the block checks the requested access kind against the stored rights. If the access is allowed, it returns the physical address: the stored frame followed by the page offset, which is not changed. If the access is not allowed, it raises a protection fault in place of the translation. When nothing matches it reports a miss. An external table walker then fetches the page entry and writes it back through the refill port.

A flush input drops every cached translation, for use on a context switch. The response is registered, so it appears one cycle after the request.

Top module: `tlb_perm`

## Requirements
- R1: After reset, `rsp_valid_o`, `rsp_hit_o`, `rsp_miss_o`, `rsp_fault_o` and `rsp_paddr_o` are all zero, and every entry is invalid, so any lookup misses.
- R2: A request accepted on one rising edge produces its response on the outputs after that edge, with `rsp_valid_o` high. When there was no request, `rsp_valid_o` and all three outcome flags are low. A valid response has exactly one of hit, miss and fault set.
- R3: On a permitted hit, `rsp_paddr_o` equals the stored frame number concatenated with the low `OFFSET_W` bits of the virtual address, unchanged.
- R4: A lookup whose page number matches no valid entry reports a miss. On a miss or a fault, `rsp_paddr_o` is zero.
- R5: `req_acc_i` encodes 00 = read, 01 = write and 10 = execute. These need rights bit 0, bit 1 and bit 2 respectively of the stored entry. Code 11 is reserved and always faults on a matching entry. A matching entry that lacks the needed right gives a fault, not a hit.
- R6: A refill of a page number that is not present is written into the lowest-indexed invalid entry. It is visible to lookups from the cycle after the refill.
- R7: When all entries are valid, a refill replaces the entry chosen by a victim pointer. The pointer is 0 after reset, advances by one on each such replacement, and wraps from the last entry to 0. A flush does not move it.
- R8: A refill whose page number is already held overwrites that entry's frame and rights, and leaves no second copy.
- R9: `flush_i` invalidates every entry in one cycle, and lookups from the next cycle on miss.
- R10: When `flush_i` and `fill_valid_i` are high in the same cycle, the flush wins and the refill is dropped.
- R11: A lookup issued in the same cycle as a refill or a flush sees the contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | VPN_W+OFFSET_W | Virtual address to translate |
| req_acc_i | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 reserved) |
| fill_valid_i | input | 1 | Refill strobe from the table walker |
| fill_vpn_i | input | VPN_W | Page number of the refill |
| fill_ppn_i | input | PPN_W | Frame number of the refill |
| fill_perm_i | input | 3 | Rights of the refill: bit 0 read, bit 1 write, bit 2 execute |
| flush_i | input | 1 | Invalidate all entries |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation delivered |
| rsp_miss_o | output | 1 | No entry; table walk needed |
| rsp_fault_o | output | 1 | Entry found but access not permitted |
| rsp_paddr_o | output | PPN_W+OFFSET_W | Physical address on a hit, zero otherwise |

## Verification
The bench builds the block with its default parameters: 8 entries, 20-bit page and frame numbers, and a 12-bit offset. With only eight entries, the capacity limit is reached after eight refills. A few more refills move the victim pointer once all the way round, which shows both the order in which free entries are used and the wrap of the pointer. With 20-bit page and frame numbers, frame values can be chosen with disjoint bit patterns, so a stale or duplicated entry would corrupt the returned address in a way the bench can see.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // bit 0 read, bit 1 write, bit 2 execute
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  localparam int PERM_W = $bits(perm_t);

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int IDX_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [VPN_W-1:0]          lk_vpn_i,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [VPN_W-1:0]          wr_vpn_i,
  input  logic [PPN_W-1:0]          wr_ppn_i,
  input  tlb_pkg::perm_t            wr_perm_i,
  input  logic                      flush_i,
  output logic                      lk_hit_o,
  output logic [PPN_W-1:0]          lk_ppn_o,
  output tlb_pkg::perm_t            lk_perm_o,
  output logic [N-1:0]              valid_o,
  output logic [N-1:0]              wr_match_o
);

  logic [N-1:0]       lk_match;
  logic [PPN_W-1:0]   ppn_w  [N];
  tlb_pkg::perm_t     perm_w [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic               v_q;
    logic [VPN_W-1:0]   t_q;
    logic [PPN_W-1:0]   p_q;
    tlb_pkg::perm_t     r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
        r_q <= '0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        v_q <= 1'b1;
        t_q <= wr_vpn_i;
        p_q <= wr_ppn_i;
        r_q <= wr_perm_i;
      end
    end

    assign valid_o[g]    = v_q;
    assign lk_match[g]   = v_q && (t_q == lk_vpn_i);
    assign wr_match_o[g] = v_q && (t_q == wr_vpn_i);
    assign ppn_w[g]      = p_q;
    assign perm_w[g]     = r_q;
  end

  // at most one entry matches, so an OR of the gated entries selects it
  always_comb begin
    lk_ppn_o  = '0;
    lk_perm_o = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_ppn_o  = lk_ppn_o | ppn_w[i];
        lk_perm_o = lk_perm_o | perm_w[i];
      end
    end
  end

  assign lk_hit_o = |lk_match;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_valid_i,
  input  logic             flush_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     dup_i,
  output logic             en_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] dup_idx, free_idx;
  logic             dup_any, free_any, use_rr;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (dup_i[i])    dup_idx  = IDX_W'(i);
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign dup_any  = |dup_i;
  assign free_any = ~&valid_i;
  assign use_rr   = !dup_any && !free_any;
  assign en_o     = fill_valid_i && !flush_i;
  assign idx_o    = dup_any ? dup_idx : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rr_q <= '0;
    else if (en_o && use_rr)  rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

endmodule

// File: rtl/tlb_rights.sv
module tlb_rights (
  input  logic [1:0]     acc_i,
  input  tlb_pkg::perm_t perm_i,
  output logic           ok_o
);
  import tlb_pkg::*;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  ok_o = perm_i.r;
      ACC_WRITE: ok_o = perm_i.w;
      ACC_EXEC:  ok_o = perm_i.x;
      default:   ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm #(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int OFFSET_W    = 12,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int VA_W       = VPN_W + OFFSET_W,
  localparam int PA_W       = PPN_W + OFFSET_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_vaddr_i,
  input  logic [1:0]           req_acc_i,
  input  logic                 fill_valid_i,
  input  logic [VPN_W-1:0]     fill_vpn_i,
  input  logic [PPN_W-1:0]     fill_ppn_i,
  input  logic [2:0]           fill_perm_i,
  input  logic                 flush_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_hit_o,
  output logic                 rsp_miss_o,
  output logic                 rsp_fault_o,
  output logic [PA_W-1:0]      rsp_paddr_o
);

  logic [VPN_W-1:0]    lk_vpn;
  logic [OFFSET_W-1:0] lk_off;
  logic                lk_hit, acc_ok, grant;
  logic [PPN_W-1:0]    lk_ppn;
  tlb_pkg::perm_t      lk_perm;
  logic [NUM_ENTRIES-1:0] ent_valid, ent_dup;
  logic                wr_en;
  logic [IDX_W-1:0]    wr_idx;

  assign lk_vpn = req_vaddr_i[VA_W-1:OFFSET_W];
  assign lk_off = req_vaddr_i[OFFSET_W-1:0];

  tlb_entry_array #(
    .N(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_vpn_i   (lk_vpn),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_vpn_i   (fill_vpn_i),
    .wr_ppn_i   (fill_ppn_i),
    .wr_perm_i  (tlb_pkg::perm_t'(fill_perm_i)),
    .flush_i    (flush_i),
    .lk_hit_o   (lk_hit),
    .lk_ppn_o   (lk_ppn),
    .lk_perm_o  (lk_perm),
    .valid_o    (ent_valid),
    .wr_match_o (ent_dup)
  );

  tlb_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_valid_i (fill_valid_i),
    .flush_i      (flush_i),
    .valid_i      (ent_valid),
    .dup_i        (ent_dup),
    .en_o         (wr_en),
    .idx_o        (wr_idx)
  );

  tlb_rights u_rights (
    .acc_i  (req_acc_i),
    .perm_i (lk_perm),
    .ok_o   (acc_ok)
  );

  assign grant = lk_hit && acc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && grant;
      rsp_miss_o  <= req_valid_i && !lk_hit;
      rsp_fault_o <= req_valid_i && lk_hit && !acc_ok;
      rsp_paddr_o <= (req_valid_i && grant) ? {lk_ppn, lk_off} : '0;
    end
  end

endmodule

// File: rtl/tlb_perm_sva.sv
module tlb_perm_sva #(
  parameter int OFFSET_W = 12,
  parameter int VA_W     = 32,
  parameter int PA_W     = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic [1:0]      req_acc_i,
  input logic            flush_i,
  input logic            rsp_valid_o,
  input logic            rsp_hit_o,
  input logic            rsp_miss_o,
  input logic            rsp_fault_o,
  input logic [PA_W-1:0] rsp_paddr_o
);

  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_idle_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1));

  a_r2_quiet_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_fault_o));

  a_r3_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!rsp_hit_o ||
      (rsp_paddr_o[OFFSET_W-1:0] == $past(req_vaddr_i[OFFSET_W-1:0]))));

  a_r4_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_miss_o || rsp_fault_o) |-> (rsp_paddr_o == '0));

  a_r5_reserved_never_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_acc_i == 2'b11)) |=> !rsp_hit_o);

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 req_valid_i |=> rsp_miss_o);

endmodule

bind tlb_perm tlb_perm_sva #(
  .OFFSET_W(OFFSET_W), .VA_W(VA_W), .PA_W(PA_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .req_acc_i   (req_acc_i),
  .flush_i     (flush_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_miss_o  (rsp_miss_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_paddr_o (rsp_paddr_o)
);

// File: tb/sim_tlb_perm.sv
module sim_tlb_perm;

  localparam int NE   = 8;
  localparam int VPNW = 20;
  localparam int PPNW = 20;
  localparam int OFFW = 12;
  localparam int VAW  = VPNW + OFFW;
  localparam int PAW  = PPNW + OFFW;

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10, RS = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [VAW-1:0]  req_vaddr = '0;
  logic [1:0]      req_acc = 2'b00;
  logic            fill_valid = 1'b0;
  logic [VPNW-1:0] fill_vpn = '0;
  logic [PPNW-1:0] fill_ppn = '0;
  logic [2:0]      fill_perm = '0;
  logic            flush = 1'b0;
  logic            rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [PAW-1:0]  rsp_paddr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  tlb_perm #(.NUM_ENTRIES(NE), .VPN_W(VPNW), .PPN_W(PPNW), .OFFSET_W(OFFW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_perm_i(fill_perm), .flush_i(flush),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {valid, hit, miss, fault, paddr}
  function automatic logic [63:0] pack_rsp(logic v, logic h, logic m, logic f,
                                           logic [PAW-1:0] pa);
    return 64'({v, h, m, f, pa});
  endfunction

  task automatic fill(input logic [VPNW-1:0] vpn, input logic [PPNW-1:0] ppn,
                      input logic [2:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // request at one negedge, response sampled at the next
  task automatic look(input string req, input logic [VPNW-1:0] vpn,
                      input logic [OFFW-1:0] off, input logic [1:0] acc,
                      input logic [1:0] kind, input logic [PPNW-1:0] ppn);
    logic [PAW-1:0] pa;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {vpn, off}; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    pa = (kind == 2'd0) ? {ppn, off} : '0;
    check(req, "response", pack_rsp(rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr),
          pack_rsp(1'b1, kind == 2'd0, kind == 2'd1, kind == 2'd2, pa));
  endtask

  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_FLT = 2'd2;

  task automatic t_reset();
    check("R1", "outputs in reset",
          pack_rsp(rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr), '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset",
          pack_rsp(rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr), '0);
    look("R1", 20'h00000, 12'h000, RD, K_MISS, '0);
  endtask

  task automatic t_basic();
    fill(20'h12345, 20'hABCDE, 3'b111);
    look("R3", 20'h12345, 12'h678, RD, K_HIT, 20'hABCDE);
    look("R3", 20'h12345, 12'h000, WR, K_HIT, 20'hABCDE);
    look("R3", 20'h12345, 12'hFFF, EX, K_HIT, 20'hABCDE);
    @(negedge clk);
    check("R2", "idle cycle",
          pack_rsp(rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr), '0);
    look("R4", 20'h54321, 12'h123, RD, K_MISS, '0);
  endtask

  task automatic t_perm();
    fill(20'h00A00, 20'h11111, 3'b001);
    fill(20'h00B00, 20'h22222, 3'b010);
    fill(20'h00C00, 20'h33333, 3'b100);
    look("R5", 20'h00A00, 12'h010, RD, K_HIT, 20'h11111);
    look("R5", 20'h00A00, 12'h010, WR, K_FLT, '0);
    look("R5", 20'h00A00, 12'h010, EX, K_FLT, '0);
    look("R5", 20'h00B00, 12'h020, RD, K_FLT, '0);
    look("R5", 20'h00B00, 12'h020, WR, K_HIT, 20'h22222);
    look("R5", 20'h00C00, 12'h030, EX, K_HIT, 20'h33333);
    look("R5", 20'h00C00, 12'h030, RD, K_FLT, '0);
    look("R5", 20'h12345, 12'h040, RS, K_FLT, '0);
  endtask

  task automatic t_same_cycle();
    // R11: fill and lookup in one cycle, lookup sees old contents
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00D00; fill_ppn = 20'h44444; fill_perm = 3'b001;
    req_valid = 1'b1; req_vaddr = {20'h00D00, 12'h005}; req_acc = RD;
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
    check("R11", "lookup with fill",
          pack_rsp(rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr),
          pack_rsp(1'b1, 1'b0, 1'b1, 1'b0, '0));
    look("R6", 20'h00D00, 12'h005, RD, K_HIT, 20'h44444);
    // R11: flush and lookup in one cycle, lookup still hits
    @(negedge clk);
    flush = 1'b1;
    req_valid = 1'b1; req_vaddr = {20'h00D00, 12'h006}; req_acc = RD;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    check("R11", "lookup with flush",
          pack_rsp(rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr),
          pack_rsp(1'b1, 1'b1, 1'b0, 1'b0, {20'h44444, 12'h006}));
    look("R9", 20'h00D00, 12'h006, RD, K_MISS, '0);
    look("R9", 20'h12345, 12'h006, RD, K_MISS, '0);
    look("R9", 20'h00A00, 12'h006, RD, K_MISS, '0);
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00E00; fill_ppn = 20'h55555; fill_perm = 3'b111;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look("R10", 20'h00E00, 12'h000, RD, K_MISS, '0);
  endtask

  task automatic t_replace();
    // table empty, victim pointer 0: Vi lands in entry i
    for (int i = 0; i < NE; i++) fill(20'(32'h70000 + i), 20'(32'h00100 + i), 3'b001);
    for (int i = 0; i < NE; i++)
      look("R6", 20'(32'h70000 + i), 12'h0AB, RD, K_HIT, 20'(32'h00100 + i));
    fill(20'h70008, 20'h00108, 3'b001);
    look("R7", 20'h70000, 12'h0, RD, K_MISS, '0);
    look("R7", 20'h70001, 12'h0, RD, K_HIT, 20'h00101);
    look("R7", 20'h70008, 12'h0, RD, K_HIT, 20'h00108);
    fill(20'h70009, 20'h00109, 3'b001);
    look("R7", 20'h70001, 12'h0, RD, K_MISS, '0);
    look("R7", 20'h70002, 12'h0, RD, K_HIT, 20'h00102);
    // entries 2..7 replaced, then the pointer wraps to entry 0 (holding V8)
    for (int i = 10; i < 16; i++) fill(20'(32'h70000 + i), 20'(32'h00100 + i), 3'b001);
    fill(20'h70010, 20'h00110, 3'b001);
    look("R7", 20'h70008, 12'h0, RD, K_MISS, '0);
    look("R7", 20'h70009, 12'h0, RD, K_HIT, 20'h00109);
    look("R7", 20'h70010, 12'h0, RD, K_HIT, 20'h00110);
  endtask

  task automatic t_dup();
    do_flush();
    fill(20'h0F00F, 20'h0F0F0, 3'b001);
    fill(20'h0F00F, 20'h00F0F, 3'b010);
    look("R8", 20'h0F00F, 12'h321, WR, K_HIT, 20'h00F0F);
    look("R8", 20'h0F00F, 12'h321, RD, K_FLT, '0);
    for (int i = 1; i < NE; i++) fill(20'(32'h60000 + i), 20'(32'h00200 + i), 3'b001);
    look("R8", 20'h0F00F, 12'h111, WR, K_HIT, 20'h00F0F);
    for (int i = 1; i < NE; i++)
      look("R8", 20'(32'h60000 + i), 12'h111, RD, K_HIT, 20'(32'h00200 + i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_perm();
    t_same_cycle();
    t_flush_fill();
    t_replace();
    t_dup();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule